// File: doc/BRIEF.md
# Byte SPI Master Port with Sticky Status Flags

This block is a byte-wide SPI master that a small processor drives through two 8-bit registers: a data register and a status/control register. Writing the data register while the port is idle launches one 8-bit exchange in mode 0. This holds even when only reception is wanted; the written byte is then a dummy. SCK idles low. MOSI presents the most significant bit first. MISO is sampled on each rising SCK edge and MOSI moves on each falling edge. Every SCK half-period lasts `HALF_DIV` core clocks.

Three sticky flags report events: transfer done, write collision and slave-select rising edge. Transfer-done and collision clear only through a two-step sequence: a status read arms the clear and the next data-register access performs it. With interrupts enabled, an interrupt acknowledge clears transfer-done instead. The slave-select flag is cleared by writing 0 to its bit. Three enable bits gate transmit, receive and slave-select sensing.

The register bus has no back-pressure. A read or write strobe is accepted in the cycle it is presented. Read data is valid combinationally in that same cycle, and side effects take place at the closing clock edge.

Top module: `spi_port_ctrl`

## Requirements
- R1: After reset both registers read 0x00, SCK and MOSI are low and the interrupt request is low.
- R2: Status register bits are: 7 transfer-done, 6 write-collision, 5 select-rise flag, 4:3 always read 0, 2 select-sense enable, 1 transmit enable, 0 receive enable. `reg_sel`=0 addresses data and `reg_sel`=1 addresses status.
- R3: A data-register write while idle starts an 8-bit MSB-first mode-0 exchange of `16*HALF_DIV` clocks. MISO is sampled on rising SCK, MOSI changes on falling SCK, and SCK is low whenever no exchange runs.
- R4: Transfer-done (bit 7) sets when the eighth bit completes. `irq_req` is high whenever transfer-done is set and `irq_en` is high; it stays low mid-exchange.
- R5: With `irq_en` high, a one-cycle `irq_ack` clears transfer-done, and the two-step sequence does not.
- R6: With `irq_en` low, transfer-done clears only when a data-register access follows a status read. Status writes in between keep the sequence armed. A data access with no preceding status read clears nothing.
- R7: A data-register write during an exchange sets write-collision (bit 6). The written byte is discarded and the running exchange continues unchanged. The flag clears through the two-step sequence.
- R8: With select-sense enable set, a rising edge on `ss_in` sets bit 5. With the enable clear, rising edges are ignored. Writing 0 to bit 5 clears it and writing 1 leaves it unchanged.
- R9: With transmit disabled, MOSI stays low throughout the exchange. With receive disabled, the received byte does not replace the data-register contents.
- R10: Writes to status bits 7 and 6 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 1 | 0 selects data register, 1 selects status register |
| reg_wr | input | 1 | Write strobe, accepted the same cycle |
| reg_rd | input | 1 | Read strobe, accepted the same cycle |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| irq_en | input | 1 | Interrupt enable |
| irq_ack | input | 1 | Interrupt service acknowledge |
| irq_req | output | 1 | Interrupt request |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| ss_in | input | 1 | Slave-select input that is watched for rising edges |

## Verification
A flag that sets or clears wrongly, or an armed state that is lost or kept too long, shows up on the status read that follows. The bench therefore reads status after every step of each clear sequence. A fault in the bit counter or the divider changes the byte that the bench-side slave captures on MOSI, or the byte that lands in the data register, within one exchange. A collision that corrupts the shifter is visible the same way. A wrong interrupt gate is visible on `irq_req` in the first cycle after the exchange ends.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;
  localparam int BYTE_W = 8;
  localparam logic SEL_DATA = 1'b0;
  localparam logic SEL_STAT = 1'b1;
  localparam int ST_DONE = 7;
  localparam int ST_COLL = 6;
  localparam int ST_SSRISE = 5;
  localparam int ST_SSEN = 2;
  localparam int ST_TXEN = 1;
  localparam int ST_RXEN = 0;

  typedef struct packed {
    logic ss_en;
    logic tx_en;
    logic rx_en;
  } port_enables_t;
endpackage

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
  parameter int DATA_W   = 8,
  parameter int HALF_DIV = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] load_byte,
  input  logic              tx_en,
  input  logic              miso,
  output logic              busy,
  output logic              done,
  output logic              sck,
  output logic              mosi,
  output logic [DATA_W-1:0] rx_byte
);
  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int CNT_W = $clog2(DATA_W);

  logic [DIV_W-1:0]  div_q;
  logic [CNT_W-1:0]  bit_q;
  logic [DATA_W-1:0] tx_sh;
  logic [DATA_W-1:0] rx_sh;
  logic              half_tick;

  assign half_tick = (div_q == DIV_W'(HALF_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      sck   <= 1'b0;
      div_q <= '0;
      bit_q <= '0;
      tx_sh <= '0;
      rx_sh <= '0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        busy  <= 1'b1;
        sck   <= 1'b0;
        div_q <= '0;
        bit_q <= '0;
        tx_sh <= load_byte;
      end else if (busy) begin
        if (half_tick) begin
          div_q <= '0;
          if (!sck) begin
            sck   <= 1'b1;
            rx_sh <= {rx_sh[DATA_W-2:0], miso};
          end else begin
            sck   <= 1'b0;
            tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
            bit_q <= bit_q + 1'b1;
            if (bit_q == CNT_W'(DATA_W - 1)) begin
              busy <= 1'b0;
              done <= 1'b1;
            end
          end
        end else begin
          div_q <= div_q + 1'b1;
        end
      end
    end
  end

  assign mosi    = busy & tx_en & tx_sh[DATA_W-1];
  assign rx_byte = rx_sh;
endmodule

// File: rtl/spi_flag_unit.sv
module spi_flag_unit #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stat_rd,
  input  logic stat_wr,
  input  logic stat_wr_ssrise,
  input  logic data_acc,
  input  logic xfer_done,
  input  logic collide,
  input  logic ss_en,
  input  logic ss_in,
  input  logic irq_en,
  input  logic irq_ack,
  output logic tc,
  output logic wcol,
  output logic ss_rise_flag,
  output logic irq_req
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   ss_prev;
  logic                   ss_rise;
  logic                   armed;
  logic                   clear_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= '0;
      ss_prev <= 1'b0;
    end else begin
      sync_q  <= {sync_q[SYNC_STAGES-2:0], ss_in};
      ss_prev <= sync_q[SYNC_STAGES-1];
    end
  end

  assign ss_rise   = sync_q[SYNC_STAGES-1] & ~ss_prev;
  assign clear_now = armed & data_acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed        <= 1'b0;
      tc           <= 1'b0;
      wcol         <= 1'b0;
      ss_rise_flag <= 1'b0;
    end else begin
      if (stat_rd)       armed <= 1'b1;
      else if (data_acc) armed <= 1'b0;

      if (xfer_done)                  tc <= 1'b1;
      else if (irq_en && irq_ack)     tc <= 1'b0;
      else if (!irq_en && clear_now)  tc <= 1'b0;

      if (collide)        wcol <= 1'b1;
      else if (clear_now) wcol <= 1'b0;

      if (ss_en && ss_rise)                ss_rise_flag <= 1'b1;
      else if (stat_wr && !stat_wr_ssrise) ss_rise_flag <= 1'b0;
    end
  end

  assign irq_req = tc & irq_en;
endmodule

// File: rtl/spi_port_ctrl.sv
module spi_port_ctrl
  import spi_port_pkg::*;
#(
  parameter int HALF_DIV    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_sel,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  input  logic              irq_en,
  input  logic              irq_ack,
  output logic              irq_req,
  output logic              spi_sck,
  output logic              spi_mosi,
  input  logic              spi_miso,
  input  logic              ss_in
);
  port_enables_t     en_q;
  logic [BYTE_W-1:0] data_q;
  logic [BYTE_W-1:0] rx_byte;
  logic              busy;
  logic              xfer_done;
  logic              data_wr;
  logic              data_acc;
  logic              stat_wr;
  logic              stat_rd;
  logic              collide;
  logic              flag_tc;
  logic              flag_wcol;
  logic              flag_ssrise;
  logic              unused_wbits;

  assign data_wr  = reg_wr & (reg_sel == SEL_DATA);
  assign data_acc = (reg_wr | reg_rd) & (reg_sel == SEL_DATA);
  assign stat_wr  = reg_wr & (reg_sel == SEL_STAT);
  assign stat_rd  = reg_rd & (reg_sel == SEL_STAT);
  assign collide  = data_wr & busy;
  assign unused_wbits = ^{reg_wdata[ST_DONE], reg_wdata[ST_COLL], reg_wdata[4:3]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (stat_wr) begin
      en_q.ss_en <= reg_wdata[ST_SSEN];
      en_q.tx_en <= reg_wdata[ST_TXEN];
      en_q.rx_en <= reg_wdata[ST_RXEN];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       data_q <= '0;
    else if (xfer_done && en_q.rx_en) data_q <= rx_byte;
  end

  spi_shift_engine #(.DATA_W(BYTE_W), .HALF_DIV(HALF_DIV)) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (data_wr),
    .load_byte (reg_wdata),
    .tx_en     (en_q.tx_en),
    .miso      (spi_miso),
    .busy      (busy),
    .done      (xfer_done),
    .sck       (spi_sck),
    .mosi      (spi_mosi),
    .rx_byte   (rx_byte)
  );

  spi_flag_unit #(.SYNC_STAGES(SYNC_STAGES)) u_flags (
    .clk            (clk),
    .rst_n          (rst_n),
    .stat_rd        (stat_rd),
    .stat_wr        (stat_wr),
    .stat_wr_ssrise (reg_wdata[ST_SSRISE]),
    .data_acc       (data_acc),
    .xfer_done      (xfer_done),
    .collide        (collide),
    .ss_en          (en_q.ss_en),
    .ss_in          (ss_in),
    .irq_en         (irq_en),
    .irq_ack        (irq_ack),
    .tc             (flag_tc),
    .wcol           (flag_wcol),
    .ss_rise_flag   (flag_ssrise),
    .irq_req        (irq_req)
  );

  always_comb begin
    if (reg_sel == SEL_STAT) begin
      reg_rdata = {flag_tc, flag_wcol, flag_ssrise, 2'b00,
                   en_q.ss_en, en_q.tx_en, en_q.rx_en};
    end else begin
      reg_rdata = data_q;
    end
  end
endmodule

// File: rtl/spi_port_checker.sv
module spi_port_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_sel,
  input logic       reg_wr,
  input logic [7:0] reg_rdata,
  input logic       irq_en,
  input logic       irq_ack,
  input logic       irq_req,
  input logic       spi_sck,
  input logic       spi_mosi,
  input logic       busy,
  input logic       xfer_done,
  input logic       tc,
  input logic       wcol,
  input logic       tx_en
);
  assert_sck_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !spi_sck);

  assert_end_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> xfer_done);

  assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_sel |-> (reg_rdata[4:3] == 2'b00));

  assert_done_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> tc);

  assert_no_irq_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tc) |-> !irq_req);

  assert_ack_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en && irq_ack && !xfer_done) |=> !tc);

  assert_collide_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_sel && busy) |=> wcol);

  assert_mosi_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> !spi_mosi);
endmodule

bind spi_port_ctrl spi_port_checker u_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_sel   (reg_sel),
  .reg_wr    (reg_wr),
  .reg_rdata (reg_rdata),
  .irq_en    (irq_en),
  .irq_ack   (irq_ack),
  .irq_req   (irq_req),
  .spi_sck   (spi_sck),
  .spi_mosi  (spi_mosi),
  .busy      (busy),
  .xfer_done (xfer_done),
  .tc        (flag_tc),
  .wcol      (flag_wcol),
  .tx_en     (en_q.tx_en)
);

// File: tb/test_spi_port_ctrl.sv
`timescale 1ns/1ps
module test_spi_port_ctrl;
  localparam int HALF_DIV = 2;
  localparam int XFER_WAIT = 16 * HALF_DIV + 8;
  localparam int NVEC = 6;
  // {tx_en, rx_en, byte written, byte on MISO, expected data reg, expected MOSI byte}
  localparam logic [33:0] VEC [NVEC] = '{
    {1'b1, 1'b1, 8'hA5, 8'h3C, 8'h3C, 8'hA5},
    {1'b1, 1'b0, 8'h5A, 8'hC3, 8'h3C, 8'h5A},
    {1'b0, 1'b1, 8'hFF, 8'h81, 8'h81, 8'h00},
    {1'b1, 1'b1, 8'h01, 8'h80, 8'h80, 8'h01},
    {1'b0, 1'b0, 8'h77, 8'h11, 8'h80, 8'h00},
    {1'b1, 1'b1, 8'h80, 8'hFE, 8'hFE, 8'h80}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_sel = 1'b0;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       irq_en = 1'b0;
  logic       irq_ack = 1'b0;
  logic       irq_req;
  logic       spi_sck;
  logic       spi_mosi;
  logic       spi_miso;
  logic       ss_in = 1'b0;
  logic [7:0] miso_sh = 8'h00;
  logic [7:0] mosi_cap = 8'h00;
  int         checks = 0;
  int         failures = 0;
  logic [7:0] rv;

  always #2 clk = ~clk;

  spi_port_ctrl #(.HALF_DIV(HALF_DIV), .SYNC_STAGES(2)) i_spi_port_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_en(irq_en), .irq_ack(irq_ack),
    .irq_req(irq_req), .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .ss_in(ss_in)
  );

  assign spi_miso = miso_sh[7];
  always @(negedge spi_sck) miso_sh <= {miso_sh[6:0], 1'b0};
  always @(posedge spi_sck) mosi_cap <= {mosi_cap[6:0], spi_mosi};

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic sel, input logic [7:0] d);
    @(negedge clk); reg_sel = sel; reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic sel, output logic [7:0] v);
    @(negedge clk); reg_sel = sel; reg_rd = 1'b1;
    #1 v = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic start_xfer(input logic [7:0] tx, input logic [7:0] rx);
    @(negedge clk); miso_sh = rx; mosi_cap = 8'h00;
    reg_write(1'b0, tx);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R1 reset state
    reg_read(1'b1, rv); check("R1 status", rv, 8'h00);
    reg_read(1'b0, rv); check("R1 data", rv, 8'h00);
    check("R1 irq/sck/mosi", {5'b0, irq_req, spi_sck, spi_mosi}, 8'h00);

    // R3 R4 R6 R9 vector table
    for (int i = 0; i < NVEC; i++) begin
      logic [7:0] en;
      en = {6'b0, VEC[i][33], VEC[i][32]};
      reg_write(1'b1, en);
      start_xfer(VEC[i][31:24], VEC[i][23:16]);
      idle(6);
      reg_read(1'b1, rv); check("R4 not done mid-transfer", rv, en);
      idle(XFER_WAIT);
      check("R4 irq low when disabled", {7'b0, irq_req}, 8'h00);
      reg_read(1'b1, rv); check("R4 R2 done flag", rv, 8'h80 | en);
      reg_read(1'b0, rv); check("R3 R9 data register", rv, VEC[i][15:8]);
      reg_read(1'b1, rv); check("R6 two-step clear", rv, en);
      check("R3 R9 MOSI byte", mosi_cap, VEC[i][7:0]);
    end

    // R6 data access without status read, then status write in between
    reg_write(1'b1, 8'h03);
    start_xfer(8'h3C, 8'h96);
    idle(XFER_WAIT);
    reg_read(1'b0, rv); check("R6 data after transfer", rv, 8'h96);
    reg_read(1'b1, rv); check("R6 no clear without status read", rv, 8'h83);
    reg_write(1'b1, 8'h03);
    reg_read(1'b0, rv);
    reg_read(1'b1, rv); check("R6 armed survives status write", rv, 8'h03);

    // R7 collision
    start_xfer(8'hC3, 8'h5A);
    idle(5);
    reg_write(1'b0, 8'h00);
    reg_read(1'b1, rv); check("R7 collision flag mid-transfer", rv, 8'h43);
    idle(XFER_WAIT);
    reg_read(1'b1, rv); check("R7 both flags", rv, 8'hC3);
    check("R7 transfer unchanged MOSI", mosi_cap, 8'hC3);
    reg_read(1'b0, rv); check("R7 received byte", rv, 8'h5A);
    reg_read(1'b1, rv); check("R7 flags cleared", rv, 8'h03);

    // R4 R5 interrupt path
    irq_en = 1'b1;
    start_xfer(8'h12, 8'h34);
    idle(XFER_WAIT);
    check("R4 irq raised", {7'b0, irq_req}, 8'h01);
    reg_read(1'b1, rv);
    reg_read(1'b0, rv);
    reg_read(1'b1, rv); check("R5 two-step ignored with irq", rv, 8'h83);
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
    check("R5 irq dropped after ack", {7'b0, irq_req}, 8'h00);
    reg_read(1'b1, rv); check("R5 done cleared by ack", rv, 8'h03);
    irq_en = 1'b0;

    // R8 select-rise flag, R10 read-only bits
    @(negedge clk); ss_in = 1'b1;
    idle(6);
    reg_read(1'b1, rv); check("R8 ignored when disabled", rv, 8'h03);
    @(negedge clk); ss_in = 1'b0;
    reg_write(1'b1, 8'h07);
    idle(6);
    @(negedge clk); ss_in = 1'b1;
    idle(6);
    reg_read(1'b1, rv); check("R8 flag on rising edge", rv, 8'h27);
    reg_write(1'b1, 8'h27);
    reg_read(1'b1, rv); check("R8 write one keeps flag", rv, 8'h27);
    reg_write(1'b1, 8'hE7);
    reg_read(1'b1, rv); check("R10 done/collision not writable", rv, 8'h27);
    reg_write(1'b1, 8'h07);
    reg_read(1'b1, rv); check("R8 write zero clears", rv, 8'h07);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule